// File: doc/BRIEF.md
# VCO Sub-Band Calibration Controller

This controller picks one of 32 oscillator sub-bands after every channel change. Software raises a start bit. On its rising edge the controller takes over the loop. It asserts a hold signal that parks the charge pump and clamps the tuning node at mid-supply. It then searches for the band whose free-running frequency at that clamp voltage lies closest to the programmed synthesis target. The search is a five-step successive approximation, most significant bit first. For each trial code the controller counts feedback-divider ticks over a window of reference-divider ticks. A trial bit survives when the oscillator proves slower than the reference, which means it produced fewer feedback ticks than there were reference ticks.

A full run takes one settle period, one window per code bit and one finish period. With the default one-tick window that is seven comparison periods. At the end the hold is released and an active-low done flag drops to 0. The chosen code stays in place until the next start edge. An init input, pulsed high, returns the controller to its power-on state and aborts any search in progress. An external-select input lets a manually supplied code drive the band output instead of the internal result. The internal result stays visible on its own status output.

Top module: `vco_band_calibrator`

## Requirements
- R1: After reset, and while no run has been made, `endcal_n` is 1, `hold_cp` is 0 and `int_code` is the mid-band code 5'b10000 (16).
- R2: A run starts only on a 0-to-1 change of `cal_start` seen between two clock edges while idle. The cycle after the edge, `hold_cp` is 1, `endcal_n` is 1 and the trial code is 5'b10000. A level held high starts nothing further.
- R3: `hold_cp` is 1 from the cycle after the start edge through the last cycle of the run. `hold_cp` is never 1 while `endcal_n` is 0.
- R4: A run consumes exactly 2 + 5·WIN_LEN reference ticks while `hold_cp` is 1. That is one settle tick, five windows of WIN_LEN ticks each, and one finish tick. On the cycle after the finish tick, `hold_cp` is 0 and `endcal_n` is 0.
- R5: A window spans the cycles after its opening reference tick up to and including its closing tick. The bit under test is kept when the feedback ticks in that window number fewer than WIN_LEN, and is cleared otherwise. The next lower bit is then set to 1 as the new trial. With a monotonic oscillator the result is the largest code whose trial was slow.
- R6: A rising edge of `cal_start` during a run is ignored. The run keeps its timing and result, and the edge does not trigger a later run.
- R7: `cal_init` high aborts any run. On the next cycle the outputs return to the R1 state. A `cal_start` level present during init is not taken as an edge afterwards.
- R8: While `ext_sel` is 1, `band_code` equals `ext_code`. The internal search and `int_code` are unaffected.
- R9: While `ext_sel` is 0, `band_code` equals `int_code`, including the trial codes during a run.
- R10: After a run, `int_code` holds its result and `endcal_n` stays 0 until the next start edge or init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ref_tick | input | 1 | One-cycle pulse per reference-divider output period |
| fb_tick | input | 1 | One-cycle pulse per feedback-divider output period |
| cal_start | input | 1 | Start bit; its rising edge begins a run |
| cal_init | input | 1 | Calibrator init; high returns to the power-on state |
| ext_sel | input | 1 | Selects the external code for the band output |
| ext_code | input | 5 | Manually supplied band code |
| band_code | output | 5 | Band code applied to the oscillator |
| int_code | output | 5 | Internal trial or result code (status) |
| hold_cp | output | 1 | Holds charge pump off and tuning node at mid-supply |
| endcal_n | output | 1 | Active-low end-of-calibration flag |

## Verification
The assertions assume that `ref_tick` and `fb_tick` are single-cycle pulses synchronous to `clk`. They also assume that `cal_init` is a synchronous level and that `rst_n` is released away from a clock edge. The stimulus produces both ticks from free-running cycle counters: a reference tick every eighth cycle, and feedback ticks every fourth cycle only while the trial code exceeds a chosen target. Because of this, every window sees either zero or two feedback ticks. All control inputs change one time unit after a rising edge, so no input ever moves at the edge where it is sampled.

// File: rtl/bandcal_pkg.sv
package bandcal_pkg;

  parameter int BAND_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETTLE  = 2'd1,
    PH_MEASURE = 2'd2,
    PH_FINISH  = 2'd3
  } phase_t;

  // Oscillator is slow when it produced fewer feedback ticks than the window length
  function automatic logic osc_is_slow(input int fb_seen, input int win_len);
    return fb_seen < win_len;
  endfunction

endpackage

// File: rtl/bc_edge_detect.sv
module bc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  // clr masks the edge so a level present during init is absorbed
  assign rise = din & ~din_q & ~clr;
endmodule

// File: rtl/bc_window_meter.sv
module bc_window_meter #(
  parameter int WIN_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic window_done,
  output logic osc_slow
);
  import bandcal_pkg::*;

  localparam int CW = (WIN_LEN < 1) ? 1 : $clog2(WIN_LEN + 1);

  logic [CW-1:0] ref_cnt;
  logic [CW-1:0] fb_cnt;
  int            fb_seen;

  assign window_done = enable & ref_tick & (ref_cnt == CW'(WIN_LEN - 1));
  assign fb_seen     = int'(fb_cnt) + int'(fb_tick);
  assign osc_slow    = osc_is_slow(fb_seen, WIN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else if (!enable || window_done) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      if (ref_tick) ref_cnt <= ref_cnt + CW'(1);
      if (fb_tick && (fb_cnt != CW'(WIN_LEN))) fb_cnt <= fb_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/bc_sequencer.sv
module bc_sequencer #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              start_rise,
  input  logic              ref_tick,
  input  logic              window_done,
  input  logic              osc_slow,
  output logic [CODE_W-1:0] code,
  output logic              hold,
  output logic              done_n,
  output logic              meter_en,
  output logic              finish_evt
);
  import bandcal_pkg::*;

  localparam int IW = (CODE_W < 2) ? 1 : $clog2(CODE_W);
  localparam logic [CODE_W-1:0] SEED = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [IW-1:0]     TOP_IDX = IW'(CODE_W - 1);

  phase_t         phase;
  logic [IW-1:0]  bit_idx;

  // Settle the tested bit, then arm the next lower bit as the new trial
  function automatic logic [CODE_W-1:0] resolve_bit(
    input logic [CODE_W-1:0] cur,
    input logic [IW-1:0]     idx,
    input logic              keep
  );
    logic [CODE_W-1:0] nxt;
    nxt      = cur;
    nxt[idx] = keep;
    if (idx != '0) nxt[idx - IW'(1)] = 1'b1;
    return nxt;
  endfunction

  assign meter_en   = (phase == PH_MEASURE);
  assign finish_evt = (phase == PH_FINISH) & ref_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_idx <= TOP_IDX;
      code    <= SEED;
      hold    <= 1'b0;
      done_n  <= 1'b1;
    end else if (init) begin
      phase   <= PH_IDLE;
      bit_idx <= TOP_IDX;
      code    <= SEED;
      hold    <= 1'b0;
      done_n  <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_rise) begin
            phase   <= PH_SETTLE;
            bit_idx <= TOP_IDX;
            code    <= SEED;
            hold    <= 1'b1;
            done_n  <= 1'b1;
          end
        end
        PH_SETTLE: begin
          if (ref_tick) phase <= PH_MEASURE;
        end
        PH_MEASURE: begin
          if (window_done) begin
            code <= resolve_bit(code, bit_idx, osc_slow);
            if (bit_idx == '0) phase <= PH_FINISH;
            else               bit_idx <= bit_idx - IW'(1);
          end
        end
        PH_FINISH: begin
          if (ref_tick) begin
            phase  <= PH_IDLE;
            hold   <= 1'b0;
            done_n <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vco_band_calibrator.sv
module vco_band_calibrator #(
  parameter int CODE_W  = bandcal_pkg::BAND_W,
  parameter int WIN_LEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              fb_tick,
  input  logic              cal_start,
  input  logic              cal_init,
  input  logic              ext_sel,
  input  logic [CODE_W-1:0] ext_code,
  output logic [CODE_W-1:0] band_code,
  output logic [CODE_W-1:0] int_code,
  output logic              hold_cp,
  output logic              endcal_n
);
  logic start_rise;
  logic window_done;
  logic osc_slow;
  logic meter_en;
  logic finish_evt;

  bc_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cal_init),
    .din   (cal_start),
    .rise  (start_rise)
  );

  bc_window_meter #(.WIN_LEN(WIN_LEN)) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (meter_en),
    .ref_tick    (ref_tick),
    .fb_tick     (fb_tick),
    .window_done (window_done),
    .osc_slow    (osc_slow)
  );

  bc_sequencer #(.CODE_W(CODE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (cal_init),
    .start_rise  (start_rise),
    .ref_tick    (ref_tick),
    .window_done (window_done),
    .osc_slow    (osc_slow),
    .code        (int_code),
    .hold        (hold_cp),
    .done_n      (endcal_n),
    .meter_en    (meter_en),
    .finish_evt  (finish_evt)
  );

  assign band_code = ext_sel ? ext_code : int_code;
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_init,
  input logic              start_rise,
  input logic              finish_evt,
  input logic              hold_cp,
  input logic              endcal_n,
  input logic [CODE_W-1:0] int_code
);
  localparam logic [CODE_W-1:0] SEED = {1'b1, {(CODE_W-1){1'b0}}};

  AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cp |-> endcal_n); // R3

  AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !hold_cp && !cal_init) |=> (hold_cp && endcal_n && int_code == SEED)); // R2

  AST_LEVEL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_cp && !start_rise && !cal_init) |=> !hold_cp); // R2

  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cp && !finish_evt && !cal_init) |=> hold_cp); // R6

  AST_FINISH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cp && finish_evt && !cal_init) |=> (!hold_cp && !endcal_n)); // R4

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_init |=> (!hold_cp && endcal_n && int_code == SEED)); // R7

  AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_cp && !start_rise && !cal_init) |=> $stable(int_code)); // R10
endmodule

bind vco_band_calibrator vbc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_init   (cal_init),
  .start_rise (start_rise),
  .finish_evt (finish_evt),
  .hold_cp    (hold_cp),
  .endcal_n   (endcal_n),
  .int_code   (int_code)
);

// File: tb/test_vco_band_calibrator.sv
`timescale 1ns/1ps
module test_vco_band_calibrator;
  localparam int W   = 5;
  localparam int WIN = 1;
  localparam int RUN_TICKS = 2 + 5 * WIN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, fb_tick = 1'b0;
  logic cal_start = 1'b0, cal_init = 1'b0, ext_sel = 1'b0;
  logic [W-1:0] ext_code = '0;
  logic [W-1:0] band_code, int_code;
  logic hold_cp, endcal_n;

  int checks = 0, errors = 0;
  int target = 0;
  int cyc = 0;
  int hold_ticks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vco_band_calibrator #(.CODE_W(W), .WIN_LEN(WIN)) i_vco_band_calibrator (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .cal_start(cal_start), .cal_init(cal_init), .ext_sel(ext_sel),
    .ext_code(ext_code), .band_code(band_code), .int_code(int_code),
    .hold_cp(hold_cp), .endcal_n(endcal_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_state = 0, m_bit = 0, m_fb = 0, m_ref = 0;
  bit  m_hold = 0, m_flag = 1, m_sp = 0;
  logic [W-1:0] m_code = 5'd16;

  always @(posedge clk) begin
    if (!rst_n || cal_init) begin
      m_state = 0; m_code = 5'd16; m_hold = 0; m_flag = 1;
      m_fb = 0; m_ref = 0;
      m_sp = rst_n ? cal_start : 1'b0;
    end else begin
      bit rise;
      rise = cal_start && !m_sp;
      m_sp = cal_start;
      case (m_state)
        0: if (rise) begin
             m_state = 1; m_code = 5'd16; m_bit = W - 1; m_hold = 1; m_flag = 1;
           end
        1: if (ref_tick) begin m_state = 2; m_fb = 0; m_ref = 0; end
        2: begin
             if (ref_tick && (m_ref + 1 == WIN)) begin
               m_code[m_bit] = ((m_fb + int'(fb_tick)) < WIN);
               if (m_bit > 0) begin m_bit--; m_code[m_bit] = 1'b1; end
               else m_state = 3;
               m_fb = 0; m_ref = 0;
             end else begin
               if (ref_tick) m_ref++;
               if (fb_tick) m_fb++;
             end
           end
        default: if (ref_tick) begin m_state = 0; m_hold = 0; m_flag = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(hold_cp == m_hold, "R3 hold_cp", hold_cp, m_hold);
      check(endcal_n == m_flag, "R4 endcal_n", endcal_n, m_flag);
      check(int_code == m_code, "R5 int_code", int_code, m_code);
      if (ext_sel) check(band_code == ext_code, "R8 band_code", band_code, ext_code);
      else         check(band_code == m_code, "R9 band_code", band_code, m_code);
      if (hold_cp && ref_tick) hold_ticks++;
    end
  end

  // Divider tick generators: ref every 8 cycles, fb fast only above target
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      ref_tick = (cyc % 8 == 0);
      fb_tick  = (int'(int_code) > target) && (cyc % 4 == 2);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic run_cal(input int tgt, input bit poke_start);
    int guard;
    target = tgt;
    cal_start = 0; step(2);
    hold_ticks = 0;
    cal_start = 1; step(1);
    check(hold_cp == 1, "R2 hold after edge", hold_cp, 1);
    if (poke_start) begin
      step(20); cal_start = 0; step(2); cal_start = 1;
    end
    guard = 0;
    while (endcal_n && guard < 1000) begin step(1); guard++; end
    check(int_code == tgt, "R5 result", int_code, tgt);
    check(hold_ticks == RUN_TICKS, poke_start ? "R6 ticks with restart edge" : "R4 ticks",
          hold_ticks, RUN_TICKS);
    check(hold_cp == 0, "R3 released", hold_cp, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    check(endcal_n == 1 && hold_cp == 0, "R1 flags", {endcal_n, hold_cp}, 2);
    check(int_code == 5'd16, "R1 code", int_code, 16);

    run_cal(21, 0);
    step(60);
    check(hold_cp == 0 && endcal_n == 0, "R2 level no restart", {hold_cp, endcal_n}, 0);
    check(int_code == 21, "R10 kept", int_code, 21);

    run_cal(0, 0);
    run_cal(31, 0);
    run_cal(10, 1);
    step(80);
    check(hold_cp == 0, "R6 no later run", hold_cp, 0);

    ext_sel = 1; ext_code = 5'd7; step(1);
    check(band_code == 5'd7, "R8 override", band_code, 7);
    check(int_code == 5'd10, "R8 internal kept", int_code, 10);
    run_cal(25, 0);
    ext_sel = 0; step(1);
    check(band_code == 5'd25, "R9 follows internal", band_code, 25);

    target = 3; cal_start = 0; step(2); cal_start = 1; step(30);
    cal_init = 1; cal_start = 0; step(1);
    check(hold_cp == 0 && endcal_n == 1, "R7 abort flags", {hold_cp, endcal_n}, 1);
    check(int_code == 5'd16, "R7 abort code", int_code, 16);
    cal_start = 1; step(1); cal_init = 0; step(20);
    check(hold_cp == 0, "R7 level during init absorbed", hold_cp, 0);
    run_cal(3, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule